// File: doc/BRIEF.md
# Coprocessor Bus Cycle Tracker

This block watches a host processor's local bus and decides, one bus cycle at a time, whether the cycle is aimed at an attached numeric coprocessor. It uses the active-low address strobe and the active-low ready input to find where each cycle begins and ends. It does not decode the address combinationally. On the edge where it accepts a new cycle, it latches four things: the memory/IO indication, the top address bit, address bit 2 and the write/read direction.

For a coprocessor cycle the block raises a start pulse for one clock. It then holds a command/data flag, a write flag and a busy flag until ready closes the cycle. A cycle whose address is 0x800000F8 reaches the command/status port. A cycle whose address is 0x800000FC reaches the data port, which carries the full 32-bit data path. While the coprocessor is being read, the block drops the enable of the local data bus transceiver, so that the coprocessor can drive the shared data lines itself. A new strobe in the same clock as the closing ready starts the next cycle at once.

Top module: `cpbus_tracker`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `cp_start`, `cp_busy`, `cp_cmd` and `cp_wr` at 0 and `xcvr_en` at 1.
- R2: A cycle counts as a coprocessor cycle only when `bus_mio_n` is 0 and `bus_a_top` is 1 at the accepting edge. Any other cycle leaves `cp_start`, `cp_busy`, `cp_cmd` and `cp_wr` at 0 for its whole length.
- R3: `cp_start` is 1 for exactly the one cycle after an edge that accepts a coprocessor cycle, and 0 otherwise.
- R4: `cp_cmd` is 1 (command/status port, address ending 0xF8) when `bus_a2` was 0 at the accepting edge, and 0 (data port, address ending 0xFC) when it was 1. The value holds for the whole cycle, whatever the address does later.
- R5: `cp_wr` is 1 for a write (`bus_wr` = 1 at the accepting edge) and 0 for a read. The value holds for the whole cycle.
- R6: `cp_busy` rises in the cycle after the accepting edge. It stays 1 until the first edge where `bus_rdy_n` is sampled 0, and falls after that edge.
- R7: A strobe sampled low on the same edge where ready ends a cycle starts the next cycle with no idle clock. `cp_busy` stays 1 if the new cycle is also a coprocessor cycle, and `cp_start` pulses again.
- R8: A strobe sampled low while a cycle is open and ready is high is ignored. The latched flags do not change.
- R9: `xcvr_en` is 0 exactly while `cp_busy` is 1 and `cp_wr` is 0 (a coprocessor read). It is 1 at all other times, including during non-coprocessor cycles.
- R10: Ready sampled low while no cycle is open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ads_n | input | 1 | Address strobe, active low |
| bus_rdy_n | input | 1 | Ready, active low; ends a cycle |
| bus_mio_n | input | 1 | Memory/IO indication; 0 means IO space |
| bus_a_top | input | 1 | Top address bit |
| bus_a2 | input | 1 | Address bit 2: 0 = command/status, 1 = data |
| bus_wr | input | 1 | Direction: 1 = write, 0 = read |
| cp_start | output | 1 | One-cycle pulse at the start of a coprocessor cycle |
| cp_busy | output | 1 | A coprocessor cycle is open |
| cp_cmd | output | 1 | Open cycle targets the command/status port |
| cp_wr | output | 1 | Open cycle is a write |
| xcvr_en | output | 1 | Local data bus transceiver enable, active high |

## Verification
Every output comes from registers that are loaded on the edge which samples the strobe or ready. Each result is therefore due exactly one clock after the edge that consumed its stimulus, and no output moves combinationally with the bus inputs. The bench drives the inputs just after a falling edge. It updates a behavioural model on the rising edge and compares all five outputs with that model at the next falling edge, which is one clock after the stimulus. Directed checks for back-to-back cycles, ignored strobes and idle ready are sampled at that same falling edge.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

    // Attributes of one bus cycle, captured when the strobe is accepted
    typedef struct packed {
        logic sel;   // cycle targets the coprocessor
        logic cmd;   // command/status port (address bit 2 low)
        logic wr;    // write direction
    } cp_attr_t;

    localparam cp_attr_t CP_ATTR_IDLE = '{sel: 1'b0, cmd: 1'b0, wr: 1'b0};

    // IO space (mio_n low) plus top address bit high selects the coprocessor
    function automatic cp_attr_t cp_decode(input logic mio_n, input logic a_top,
                                           input logic a2, input logic wr);
        cp_attr_t r;
        r.sel = ~mio_n & a_top;
        r.cmd = ~a2;
        r.wr  = wr;
        return r;
    endfunction

endpackage

// File: rtl/cpbus_decode.sv
module cpbus_decode
    import cpbus_pkg::*;
(
    input  logic     mio_n,
    input  logic     a_top,
    input  logic     a2,
    input  logic     wr,
    output cp_attr_t attr
);

    always_comb begin
        attr = cp_decode(mio_n, a_top, a2, wr);
    end

endmodule

// File: rtl/cpbus_frame.sv
module cpbus_frame
    import cpbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ads_n,
    input  logic     rdy_n,
    input  cp_attr_t attr_in,
    output logic     open_q,
    output logic     start_q,
    output cp_attr_t attr_q
);

    typedef enum logic {ST_IDLE = 1'b0, ST_OPEN = 1'b1} frame_st_t;

    frame_st_t st_q;
    logic      accept;
    logic      closing;

    // A strobe is taken when nothing is open, or when ready closes the open cycle
    assign closing = (st_q == ST_OPEN) && !rdy_n;
    assign accept  = !ads_n && ((st_q == ST_IDLE) || closing);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            start_q <= 1'b0;
            attr_q  <= CP_ATTR_IDLE;
        end else begin
            start_q <= 1'b0;
            if (accept) begin
                st_q    <= ST_OPEN;
                attr_q  <= attr_in;
                start_q <= attr_in.sel;
            end else if (closing) begin
                st_q    <= ST_IDLE;
                attr_q  <= CP_ATTR_IDLE;
            end
        end
    end

    assign open_q = (st_q == ST_OPEN);

    // R6: an open cycle without ready stays open
    a_r6_open_holds: assert property (@(posedge clk) disable iff (rst)
        (open_q && rdy_n) |=> open_q);

    // R8: latched attributes hold while no ready arrives
    a_r8_attr_stable: assert property (@(posedge clk) disable iff (rst)
        (open_q && rdy_n) |=> $stable(attr_q));

    // R10: ready while idle with no strobe leaves the tracker idle
    a_r10_idle_ready: assert property (@(posedge clk) disable iff (rst)
        (!open_q && ads_n) |=> !open_q);

endmodule

// File: rtl/cpbus_xcvr.sv
module cpbus_xcvr (
    input  logic clk,
    input  logic rst,
    input  logic cp_open,
    input  logic cp_write,
    output logic xcvr_en
);

    // Release the shared data lines only while the coprocessor is read
    assign xcvr_en = !(cp_open && !cp_write);

    // R9: enable is high whenever no coprocessor cycle is open
    a_r9_enable_idle: assert property (@(posedge clk) disable iff (rst)
        !cp_open |-> xcvr_en);

endmodule

// File: rtl/cpbus_tracker.sv
module cpbus_tracker
    import cpbus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_ads_n,
    input  logic bus_rdy_n,
    input  logic bus_mio_n,
    input  logic bus_a_top,
    input  logic bus_a2,
    input  logic bus_wr,
    output logic cp_start,
    output logic cp_busy,
    output logic cp_cmd,
    output logic cp_wr,
    output logic xcvr_en
);

    cp_attr_t attr_now;
    cp_attr_t attr_q;
    logic     open_q;
    logic     start_q;

    cpbus_decode u_decode (
        .mio_n (bus_mio_n),
        .a_top (bus_a_top),
        .a2    (bus_a2),
        .wr    (bus_wr),
        .attr  (attr_now)
    );

    cpbus_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .ads_n   (bus_ads_n),
        .rdy_n   (bus_rdy_n),
        .attr_in (attr_now),
        .open_q  (open_q),
        .start_q (start_q),
        .attr_q  (attr_q)
    );

    assign cp_busy  = open_q && attr_q.sel;
    assign cp_cmd   = cp_busy && attr_q.cmd;
    assign cp_wr    = cp_busy && attr_q.wr;
    assign cp_start = start_q;

    cpbus_xcvr u_xcvr (
        .clk      (clk),
        .rst      (rst),
        .cp_open  (cp_busy),
        .cp_write (cp_wr),
        .xcvr_en  (xcvr_en)
    );

    // R2: a start pulse only follows a qualified select on the bus
    a_r2_select_qual: assert property (@(posedge clk) disable iff (rst)
        cp_start |-> $past(!bus_mio_n && bus_a_top && !bus_ads_n));

    // R3: a start pulse always belongs to an open coprocessor cycle
    a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
        cp_start |-> cp_busy);

    // R4: the port flag does not move inside a cycle without ready
    a_r4_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (cp_busy && bus_rdy_n) |=> $stable(cp_cmd));

    // R5: the direction flag does not move inside a cycle without ready
    a_r5_wr_held: assert property (@(posedge clk) disable iff (rst)
        (cp_busy && bus_rdy_n) |=> $stable(cp_wr));

    // R9: a coprocessor read keeps the transceiver off
    a_r9_read_off: assert property (@(posedge clk) disable iff (rst)
        (cp_busy && !cp_wr) |-> !xcvr_en);

endmodule

// File: tb/cpbus_tracker_test.sv
module cpbus_tracker_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ads_n = 1'b1, rdy_n = 1'b1, mio_n = 1'b1, a_top = 1'b0, a2 = 1'b0, wr = 1'b0;
    logic cp_start, cp_busy, cp_cmd, cp_wr, xcvr_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_open = 0, m_sel = 0, m_cmd = 0, m_wr = 0, m_start = 0;

    always #10 clk = ~clk;

    cpbus_tracker uut (
        .clk(clk), .rst(rst), .bus_ads_n(ads_n), .bus_rdy_n(rdy_n),
        .bus_mio_n(mio_n), .bus_a_top(a_top), .bus_a2(a2), .bus_wr(wr),
        .cp_start(cp_start), .cp_busy(cp_busy), .cp_cmd(cp_cmd),
        .cp_wr(cp_wr), .xcvr_en(xcvr_en)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_open = 0; m_sel = 0; m_cmd = 0; m_wr = 0; m_start = 0;
        end else begin
            m_start = 0;
            if (!ads_n && (m_open == 0 || !rdy_n)) begin
                m_open  = 1;
                m_sel   = (!mio_n && a_top) ? 1 : 0;
                m_cmd   = a2 ? 0 : 1;
                m_wr    = wr ? 1 : 0;
                m_start = m_sel;
            end else if (m_open == 1 && !rdy_n) begin
                m_open = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int busy;
        busy = m_open & m_sel;
        chk("R3 cp_start", cp_start, m_start[0]);
        chk("R6 cp_busy", cp_busy, busy[0]);
        chk("R4 cp_cmd", cp_cmd, (busy & m_cmd) != 0);
        chk("R5 cp_wr", cp_wr, (busy & m_wr) != 0);
        chk("R9 xcvr_en", xcvr_en, !(busy == 1 && m_wr == 0));
    endtask

    // drive one clock of bus inputs, then compare one clock later
    task automatic tick(input logic s, input logic r, input logic m,
                        input logic t, input logic b2, input logic w);
        ads_n = s; rdy_n = r; mio_n = m; a_top = t; a2 = b2; wr = w;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1, 1, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 start", cp_start, 1'b0);
        chk("R1 busy", cp_busy, 1'b0);
        chk("R1 cmd", cp_cmd, 1'b0);
        chk("R1 wr", cp_wr, 1'b0);
        chk("R1 xcvr", xcvr_en, 1'b1);
        rst = 1'b0;
        idle(2);

        // command write to 0x800000F8, two wait states
        tick(0, 1, 0, 1, 0, 1);
        chk("R3 start pulse", cp_start, 1'b1);
        chk("R4 command port", cp_cmd, 1'b1);
        tick(1, 1, 1, 0, 1, 0);   // address changes mid-cycle
        chk("R4 cmd held", cp_cmd, 1'b1);
        chk("R5 wr held", cp_wr, 1'b1);
        chk("R3 pulse ends", cp_start, 1'b0);
        tick(1, 0, 1, 0, 0, 0);
        chk("R6 busy falls", cp_busy, 1'b0);
        idle(1);

        // data read from 0x800000FC
        tick(0, 1, 0, 1, 1, 0);
        chk("R9 xcvr off on read", xcvr_en, 1'b0);
        chk("R4 data port", cp_cmd, 1'b0);
        tick(0, 1, 1, 0, 0, 1);   // strobe without ready is ignored
        chk("R8 strobe ignored", cp_start, 1'b0);
        chk("R8 wr unchanged", cp_wr, 1'b0);
        tick(1, 1, 1, 0, 0, 0);
        tick(1, 0, 1, 0, 0, 0);
        chk("R9 xcvr back on", xcvr_en, 1'b1);

        // memory-space cycle and low top bit: not coprocessor cycles
        tick(0, 1, 1, 1, 0, 0);
        chk("R2 memory space", cp_busy, 1'b0);
        chk("R9 xcvr normal", xcvr_en, 1'b1);
        tick(1, 0, 0, 0, 0, 0);
        tick(0, 1, 0, 0, 1, 0);
        chk("R2 top bit low", cp_start, 1'b0);
        tick(1, 1, 0, 0, 0, 0);
        tick(1, 0, 0, 0, 0, 0);

        // ready while idle
        tick(1, 0, 0, 1, 0, 0);
        chk("R10 idle ready", cp_busy, 1'b0);

        // back-to-back: write data, then read command in the closing clock
        tick(0, 1, 0, 1, 1, 1);
        tick(0, 0, 0, 1, 0, 0);
        chk("R7 restart pulse", cp_start, 1'b1);
        chk("R7 busy kept", cp_busy, 1'b1);
        chk("R7 new direction", cp_wr, 1'b0);
        tick(0, 0, 0, 1, 1, 1);   // zero-wait third cycle
        chk("R7 third start", cp_start, 1'b1);
        tick(0, 0, 1, 1, 0, 0);   // next one not for coprocessor
        chk("R7 into non-cp", cp_busy, 1'b0);
        tick(1, 0, 0, 0, 0, 0);
        idle(2);

        // reset in the middle of a read
        tick(0, 1, 0, 1, 0, 0);
        rst = 1'b1;
        tick(1, 1, 1, 0, 0, 0);
        chk("R1 mid-cycle reset", xcvr_en, 1'b1);
        rst = 1'b0;
        idle(2);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule